// File: doc/BRIEF.md
# Row/Column Multiplexed Memory Command Sequencer

This block sits between a simple word request port and a memory that takes its address in two halves over one shared set of address lines. Every request address is cut into a row part, taken from the upper half, and a column part, taken from the lower half. To reach a row, the sequencer first sends an activate command carrying the row. It then sends a read or write column command carrying the column. Commands are encoded on four active-low strobes: chip select, row strobe, column strobe and write enable.

The sequencer keeps the last activated row open. A later request to the same row needs only a single column command, so a run of hits can go out at one column command per cycle. A request to a different row first closes the open row with a precharge, then waits two cycles, then activates the new row. After every activate there are two NOP cycles before the column command. While nothing is pending the memory is deselected.

Top module: `rc_cmd_seq`

## Requirements
- R1: The row is `req_addr[ADDR_W-1:HALF_W]` and the column is `req_addr[HALF_W-1:0]`. An activate drives the row on `mem_addr`, and a read or write command drives the column on `mem_addr`.
- R2: The strobe encoding, written as {cs_n,ras_n,cas_n,we_n}, is: deselect 1xxx, NOP 0111, activate 0011, read 0101, write 0100, precharge 0010.
- R3: In idle with no request, the outputs show deselect (`mem_cs_n`=1) and `req_ready` is 1.
- R4: Exactly two NOP cycles separate an activate from the column command that follows it.
- R5: A request whose row differs from the open row produces precharge, NOP, NOP, activate of the new row, and then the R4 sequence.
- R6: A request that hits the open row is accepted in idle and gives only a column command, in the cycle after acceptance. Consecutive hits give one column command per cycle.
- R7: After reset no row is open. The first access issues an activate without a precharge.
- R8: `req_ready` is 0 from the precharge or activate cycle until the column command cycle, and no request is accepted then.
- R9: A write command drives the request's data on `mem_wdata` in the same cycle. Other commands drive zero on `mem_wdata`.
- R10: While `rst` is high, the outputs are deselect with `req_ready`=1 and no row open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | HALF_W | Shared row/column address |
| mem_wdata | output | DATA_W | Write data, valid with write command |

## Verification
The bench visits every one of the 16 rows. Each visit is a row miss followed by back-to-back hits to varied columns, which separates the three command shapes: cold activate, precharge-then-activate, and column only. A ping-pong pattern between two rows forces a precharge on every access. Mixing reads and writes checks both the write-enable level and the data lane. Idle gaps between bursts show that deselect, rather than NOP, fills cycles with no work.

// File: rtl/rc_cmd_pkg.sv
package rc_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PGAP,
        ST_AGAP
    } seq_state_e;

    // R2: strobe encoding of every command
    function automatic strobe_t encode_cmd(cmd_e c);
        strobe_t s;
        case (c)
            CMD_NOP:  s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_ACT:  s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_RD:   s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            CMD_WR:   s = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
            CMD_PRE:  s = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            default:  s = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
        return s;
    endfunction

    function automatic cmd_e col_cmd(logic is_write);
        return is_write ? CMD_WR : CMD_RD;
    endfunction

endpackage

// File: rtl/rc_addr_split.sv
module rc_addr_split #(
    parameter int ADDR_W       = 8,
    parameter bit ROW_IN_UPPER = 1'b1,
    localparam int HALF_W      = ADDR_W / 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [HALF_W-1:0] row,
    output logic [HALF_W-1:0] col
);
    generate
        if (ROW_IN_UPPER) begin : g_row_hi
            assign row = addr[ADDR_W-1:HALF_W];
            assign col = addr[HALF_W-1:0];
        end else begin : g_row_lo
            assign row = addr[HALF_W-1:0];
            assign col = addr[ADDR_W-1:HALF_W];
        end
    endgenerate
endmodule

// File: rtl/rc_open_row.sv
module rc_open_row #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_fire,
    input  logic [HALF_W-1:0] act_row,
    input  logic [HALF_W-1:0] probe_row,
    output logic              row_open,
    output logic [HALF_W-1:0] row_q,
    output logic              hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
            row_q    <= '0;
        end else if (act_fire) begin
            row_open <= 1'b1;
            row_q    <= act_row;
        end
    end

    assign hit = row_open && (row_q == probe_row);

    // R7: a row only becomes open through an activate
    a_r7_open_by_act: assert property (@(posedge clk) disable iff (rst)
        $rose(row_open) |-> $past(act_fire));
endmodule

// File: rtl/rc_cmd_fsm.sv
module rc_cmd_fsm
    import rc_cmd_pkg::*;
#(
    parameter int HALF_W  = 4,
    parameter int DATA_W  = 8,
    parameter int PRE_GAP = 2,
    parameter int ACT_GAP = 2,
    localparam int GAP_MAX = (PRE_GAP > ACT_GAP) ? PRE_GAP : ACT_GAP,
    localparam int CNT_W   = $clog2(GAP_MAX + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [HALF_W-1:0] req_row,
    input  logic [HALF_W-1:0] req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              row_open,
    input  logic              row_hit,
    output logic              ready,
    output cmd_e              nxt_cmd,
    output logic [HALF_W-1:0] nxt_addr,
    output logic [DATA_W-1:0] nxt_wdata,
    output logic              act_fire,
    output logic [HALF_W-1:0] act_row
);
    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              p_write_q;
    logic [HALF_W-1:0] p_row_q, p_col_q;
    logic [DATA_W-1:0] p_wdata_q;
    logic              accept, latch;

    assign ready  = (state_q == ST_IDLE);
    assign accept = ready && req_valid;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        nxt_cmd   = CMD_DESEL;
        nxt_addr  = '0;
        nxt_wdata = '0;
        act_fire  = 1'b0;
        act_row   = p_row_q;
        latch     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (row_hit) begin
                        nxt_cmd   = col_cmd(req_write);
                        nxt_addr  = req_col;
                        nxt_wdata = req_write ? req_wdata : '0;
                    end else if (row_open) begin
                        nxt_cmd = CMD_PRE;
                        latch   = 1'b1;
                        state_d = ST_PGAP;
                        cnt_d   = CNT_W'(PRE_GAP);
                    end else begin
                        nxt_cmd  = CMD_ACT;
                        nxt_addr = req_row;
                        act_fire = 1'b1;
                        act_row  = req_row;
                        latch    = 1'b1;
                        state_d  = ST_AGAP;
                        cnt_d    = CNT_W'(ACT_GAP);
                    end
                end
            end
            ST_PGAP: begin
                if (cnt_q != '0) begin
                    nxt_cmd = CMD_NOP;
                    cnt_d   = cnt_q - 1'b1;
                end else begin
                    nxt_cmd  = CMD_ACT;
                    nxt_addr = p_row_q;
                    act_fire = 1'b1;
                    state_d  = ST_AGAP;
                    cnt_d    = CNT_W'(ACT_GAP);
                end
            end
            ST_AGAP: begin
                if (cnt_q != '0) begin
                    nxt_cmd = CMD_NOP;
                    cnt_d   = cnt_q - 1'b1;
                end else begin
                    nxt_cmd   = col_cmd(p_write_q);
                    nxt_addr  = p_col_q;
                    nxt_wdata = p_write_q ? p_wdata_q : '0;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            p_write_q <= 1'b0;
            p_row_q   <= '0;
            p_col_q   <= '0;
            p_wdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (latch) begin
                p_write_q <= req_write;
                p_row_q   <= req_row;
                p_col_q   <= req_col;
                p_wdata_q <= req_wdata;
            end
        end
    end

    // R8: a busy sequence never leaves the idle state through a hit path
    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE) || $past(cnt_q) == '0);
endmodule

// File: rtl/rc_pin_drive.sv
module rc_pin_drive
    import rc_cmd_pkg::*;
#(
    parameter int HALF_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              nxt_cmd,
    input  logic [HALF_W-1:0] nxt_addr,
    input  logic [DATA_W-1:0] nxt_wdata,
    output strobe_t           pins,
    output logic [HALF_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins  <= encode_cmd(CMD_DESEL);
            addr  <= '0;
            wdata <= '0;
        end else begin
            pins  <= encode_cmd(nxt_cmd);
            addr  <= nxt_addr;
            wdata <= nxt_wdata;
        end
    end
endmodule

// File: rtl/rc_cmd_seq.sv
module rc_cmd_seq
    import rc_cmd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int PRE_GAP = 2,
    parameter int ACT_GAP = 2,
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [HALF_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic [HALF_W-1:0] req_row, req_col, act_row, row_q, nxt_addr;
    logic [DATA_W-1:0] nxt_wdata;
    logic              row_open, row_hit, act_fire;
    cmd_e              nxt_cmd;
    strobe_t           pins;

    rc_addr_split #(.ADDR_W(ADDR_W), .ROW_IN_UPPER(1'b1)) u_split (
        .addr (req_addr),
        .row  (req_row),
        .col  (req_col)
    );

    rc_open_row #(.HALF_W(HALF_W)) u_row (
        .clk       (clk),
        .rst       (rst),
        .act_fire  (act_fire),
        .act_row   (act_row),
        .probe_row (req_row),
        .row_open  (row_open),
        .row_q     (row_q),
        .hit       (row_hit)
    );

    rc_cmd_fsm #(
        .HALF_W (HALF_W), .DATA_W (DATA_W),
        .PRE_GAP(PRE_GAP), .ACT_GAP(ACT_GAP)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_wdata (req_wdata),
        .row_open  (row_open),
        .row_hit   (row_hit),
        .ready     (req_ready),
        .nxt_cmd   (nxt_cmd),
        .nxt_addr  (nxt_addr),
        .nxt_wdata (nxt_wdata),
        .act_fire  (act_fire),
        .act_row   (act_row)
    );

    rc_pin_drive #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .nxt_cmd   (nxt_cmd),
        .nxt_addr  (nxt_addr),
        .nxt_wdata (nxt_wdata),
        .pins      (pins),
        .addr      (mem_addr),
        .wdata     (mem_wdata)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_ras_n = pins.ras_n;
    assign mem_cas_n = pins.cas_n;
    assign mem_we_n  = pins.we_n;

    logic is_act, is_pre, is_nop, is_col;
    assign is_act = (pins == 4'b0011);
    assign is_pre = (pins == 4'b0010);
    assign is_nop = (pins == 4'b0111);
    assign is_col = !pins.cs_n && pins.ras_n && !pins.cas_n;

    // R1: activate carries the row that the tracker now holds open
    a_r1_act_row: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (mem_addr == row_q));
    // R4: at least two NOPs follow an activate
    a_r4_act_nop1: assert property (@(posedge clk) disable iff (rst)
        is_act |=> is_nop);
    a_r4_act_nop2: assert property (@(posedge clk) disable iff (rst)
        $past(is_act, 2) |-> is_nop);
    // R5: at least two NOPs follow a precharge
    a_r5_pre_nop1: assert property (@(posedge clk) disable iff (rst)
        is_pre |=> is_nop);
    a_r5_pre_nop2: assert property (@(posedge clk) disable iff (rst)
        $past(is_pre, 2) |-> is_nop);
    // R6: column commands only go to an open row
    a_r6_col_open: assert property (@(posedge clk) disable iff (rst)
        is_col |-> row_open);
    // R8: not ready while a precharge or activate is on the pins
    a_r8_busy: assert property (@(posedge clk) disable iff (rst)
        (is_pre || is_act) |-> !req_ready);
    // R9: data lane is zero unless a write is on the pins
    a_r9_wdata_zero: assert property (@(posedge clk) disable iff (rst)
        !(is_col && !pins.we_n) |-> (mem_wdata == '0));
endmodule

// File: tb/test_rc_cmd_seq.sv
module test_rc_cmd_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit m_open  = 1'b0;
    logic [3:0] m_row = '0;

    rc_cmd_seq i_rc_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp=<50000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    endfunction

    // R2 encodings: NOP 0111, ACT 0011, RD 0101, WR 0100, PRE 0010
    task automatic see(logic [3:0] exp, string tag);
        chk(pins() == exp, tag, int'(pins()), int'(exp));
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        chk(mem_cs_n == 1'b1, "R3 deselect", int'(mem_cs_n), 1);
        chk(req_ready == 1'b1, "R3 ready", int'(req_ready), 1);
    endtask

    task automatic issue(bit w, logic [3:0] row, logic [3:0] col, logic [7:0] d);
        bit hit = m_open && (m_row == row);
        bit pre = m_open && (m_row != row);
        chk(req_ready == 1'b1, "R3 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_write = w; req_addr = {row, col}; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (pre) begin
            see(4'b0010, "R5 precharge");
            chk(req_ready == 1'b0, "R8 busy after precharge", int'(req_ready), 0);
            @(negedge clk); see(4'b0111, "R5 nop1");
            @(negedge clk); see(4'b0111, "R5 nop2");
            @(negedge clk);
        end
        if (!hit) begin
            see(4'b0011, pre ? "R5 activate" : "R7 first activate");
            chk(mem_addr == row, "R1 row half", int'(mem_addr), int'(row));
            chk(req_ready == 1'b0, "R8 busy after activate", int'(req_ready), 0);
            @(negedge clk); see(4'b0111, "R4 nop1");
            @(negedge clk); see(4'b0111, "R4 nop2");
            @(negedge clk);
        end
        see(w ? 4'b0100 : 4'b0101, hit ? "R6 hit column" : "R4 column");
        chk(mem_addr == col, "R1 column half", int'(mem_addr), int'(col));
        chk(mem_wdata == (w ? d : 8'h00), "R9 write data", int'(mem_wdata), int'(w ? d : 8'h00));
        m_open = 1'b1;
        m_row  = row;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n == 1'b1, "R10 reset deselect", int'(mem_cs_n), 1);
        chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
        rst = 1'b0;
        idle_cycle();
        issue(1'b0, 4'd3, 4'd9, 8'h00);
        issue(1'b1, 4'd3, 4'd2, 8'h5A);
        idle_cycle();
        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 3; k++) begin
                logic [3:0] c = 4'((r * 5 + k * 7) % 16);
                issue(bit'((r + k) % 2), 4'(r), c, 8'(r * 7 + k * 29 + 1));
            end
            if (r % 4 == 0) idle_cycle();
        end
        for (int p = 0; p < 6; p++)
            issue(bit'(p % 2), (p % 2 == 0) ? 4'd2 : 4'd9, 4'(p), 8'(p * 13 + 3));
        idle_cycle();
        rst = 1'b1;
        @(negedge clk);
        chk(mem_cs_n == 1'b1, "R10 reset again", int'(mem_cs_n), 1);
        rst = 1'b0;
        m_open = 1'b0;
        issue(1'b1, 4'd9, 4'd4, 8'hC3);
        idle_cycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule